// File: doc/BRIEF.md
# I2C Target Register Interface

This block is a target on a two-wire open-drain I2C bus. It gives a bus controller write and read access to a bank of eight 8-bit registers. SCL and SDA are sampled with the system clock through a two-flop synchronizer, and START and STOP conditions are found by watching SDA change while SCL is high. The target answers only to the fixed 7-bit address 7'h34. The first byte after a START is therefore 0x68 for a write and 0x69 for a read.

A write carries a register-pointer byte and then any number of data bytes. Each data byte goes to the register the pointer selects, and the pointer then steps forward, wrapping within the bank. A read returns the register at the pointer, MSB first, and advances the pointer after each byte until the controller answers with a no-acknowledge. A repeated START is handled exactly like a first START, so a pointer write followed by a repeated START and a read address is the normal way to read a chosen register. The block never drives SDA high. It only pulls SDA low through an active-low enable. A parallel readback port exposes any register for inspection.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, SDA is released (sda_drive_no_o = 1) and all eight registers read 0x00.
- R2: The address bytes 0x68 (write) and 0x69 (read) are acknowledged. The ACK holds SDA low for the whole high phase of the ninth SCL pulse.
- R3: An address byte whose upper seven bits differ from 7'h34 gets no ACK. The target then leaves SDA released and ignores all bytes until the next START.
- R4: In a write, the first byte after the address sets the pointer from its low three bits, and the upper five bits are ignored. The next byte is written to that register, and every byte of an addressed write is acknowledged.
- R5: Each further data byte in the same write goes to the next register, and the pointer wraps from 7 to 0.
- R6: In a read, the target sends the register at the pointer MSB first and increments the pointer with wrap. It sends the next register when the controller ACKs (SDA low on the ninth pulse). The pointer value carries over between transfers.
- R7: After a NACK (SDA high on the ninth pulse) of a read byte, the target keeps SDA released until the next START or STOP.
- R8: A repeated START (SDA falling while SCL is high, with no STOP before it) restarts address reception exactly like a first START.
- R9: While the bus is free (after reset or a STOP, before any START), SCL pulses are ignored: there is no ACK, no SDA drive and no register change.
- R10: The target changes SDA only while SCL is low, so data it sends is stable over each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_drive_no_o | output | 1 | SDA pull-down enable, active low (0 pulls SDA low, 1 releases it) |
| regs_sel_i | input | 3 | Register index for the readback port |
| regs_val_o | output | 8 | Contents of the register chosen by regs_sel_i |

## Verification
The hardest state to reach from the ports is a data transfer that follows a repeated START, where the pointer left by an earlier write phase must carry into the read. The bench reaches it by writing only a pointer byte and issuing a repeated START straight into a read address, then checking each returned byte against a model of both the pointer and the registers. A second sequence places a repeated START after a rejected address, to show that the ignore state is left only through START. A third drives SCL pulses with no START at all, to show that a free bus has no effect.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_ACK_TX,
    ST_RD,
    ST_ACK_RX,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;

  // idle bus is high: reset chains to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [AW-1:0]     dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs_q[i] <= '0;
      else if (we_i && addr_i == AW'(i))   regs_q[i] <= wdata_i;
    end
  end

  assign rdata_o    = regs_q[addr_i];
  assign dbg_data_o = regs_q[dbg_addr_i];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int          NUM_REGS = 8,
  parameter int          DATA_W   = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'h34,
  localparam int         AW       = $clog2(NUM_REGS),
  localparam int         CW       = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              reg_we_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              sda_drive_no_o,
  output logic              busy_o,
  output logic              addr_phase_o,
  output logic              ack_tx_o
);
  tgt_state_e        state_q;
  logic [CW-1:0]     bit_cnt_q;
  logic [DATA_W-1:0] rx_q, tx_q;
  logic [AW-1:0]     ptr_q;
  logic              rw_q, ptr_phase_q, got_ack_q, drv_q;
  logic              byte_end;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(NUM_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign byte_end = scl_fall_i && (bit_cnt_q == CW'(DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      ptr_q       <= '0;
      rw_q        <= 1'b0;
      ptr_phase_q <= 1'b0;
      got_ack_q   <= 1'b0;
      drv_q       <= 1'b1;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      drv_q     <= 1'b1;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      drv_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i && bit_cnt_q != CW'(DATA_W)) begin
            rx_q      <= {rx_q[DATA_W-2:0], sda_s_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
          if (byte_end) begin
            if (state_q == ST_ADDR) begin
              if (rx_q[DATA_W-1:1] == DEV_ADDR) begin
                rw_q        <= rx_q[0];
                ptr_phase_q <= 1'b1;
                drv_q       <= 1'b0;
                state_q     <= ST_ACK_TX;
              end else begin
                state_q <= ST_WAIT;
              end
            end else begin
              if (ptr_phase_q) begin
                ptr_q       <= rx_q[AW-1:0];
                ptr_phase_q <= 1'b0;
              end else begin
                ptr_q <= ptr_next(ptr_q);
              end
              drv_q   <= 1'b0;
              state_q <= ST_ACK_TX;
            end
          end
        end
        ST_ACK_TX: begin
          if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data_i;
              drv_q   <= rd_data_i[DATA_W-1];
              ptr_q   <= ptr_next(ptr_q);
              state_q <= ST_RD;
            end else begin
              drv_q   <= 1'b1;
              state_q <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_rise_i) bit_cnt_q <= bit_cnt_q + 1'b1;
          if (byte_end) begin
            drv_q   <= 1'b1;
            state_q <= ST_ACK_RX;
          end else if (scl_fall_i) begin
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
            drv_q <= tx_q[DATA_W-2];
          end
        end
        ST_ACK_RX: begin
          if (scl_rise_i) got_ack_q <= ~sda_s_i;
          if (scl_fall_i) begin
            if (got_ack_q) begin
              bit_cnt_q <= '0;
              tx_q      <= rd_data_i;
              drv_q     <= rd_data_i[DATA_W-1];
              ptr_q     <= ptr_next(ptr_q);
              state_q   <= ST_RD;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // data byte lands on the falling edge that ends its eighth bit
  assign reg_we_o       = (state_q == ST_WR) && byte_end && !ptr_phase_q && !start_i && !stop_i;
  assign reg_addr_o     = ptr_q;
  assign reg_wdata_o    = rx_q;
  assign sda_drive_no_o = drv_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign addr_phase_o   = (state_q == ST_ADDR);
  assign ack_tx_o       = (state_q == ST_ACK_TX);
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int         NUM_REGS    = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h34,
  localparam int        AW          = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_no_o,
  input  logic [AW-1:0]     regs_sel_i,
  output logic [DATA_W-1:0] regs_val_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              reg_we, bus_busy, addr_phase, ack_tx;
  logic [AW-1:0]     reg_addr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_tgt_fsm #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sda_s_i        (sda_s),
    .scl_rise_i     (scl_rise),
    .scl_fall_i     (scl_fall),
    .start_i        (start_det),
    .stop_i         (stop_det),
    .rd_data_i      (reg_rdata),
    .reg_we_o       (reg_we),
    .reg_addr_o     (reg_addr),
    .reg_wdata_o    (reg_wdata),
    .sda_drive_no_o (sda_drive_no_o),
    .busy_o         (bus_busy),
    .addr_phase_o   (addr_phase),
    .ack_tx_o       (ack_tx)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .dbg_addr_i (regs_sel_i),
    .dbg_data_o (regs_val_o)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic bus_busy,
  input logic addr_phase,
  input logic ack_tx,
  input logic reg_we,
  input logic sda_drive_no
);
  // R2
  ack_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_tx && scl_s |-> !sda_drive_no);

  // R4
  write_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |-> bus_busy && !scl_s);

  // R7
  stop_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det && !start_det |=> !bus_busy && sda_drive_no);

  // R8
  start_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> addr_phase && sda_drive_no);

  // R9
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_busy |-> sda_drive_no);

  // R10
  sda_change_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_drive_no) && !$past(start_det || stop_det) |-> !$past(scl_s));
endmodule

bind i2c_reg_target i2c_tgt_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_s        (scl_s),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .bus_busy     (bus_busy),
  .addr_phase   (addr_phase),
  .ack_tx       (ack_tx),
  .reg_we       (reg_we),
  .sda_drive_no (sda_drive_no_o)
);

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_b = 1'b1;
  logic       sda_c = 1'b1;
  logic       drv_n;
  logic       sda_line;
  logic [2:0] sel = '0;
  logic [7:0] val;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] exp_regs [8];
  logic [2:0] exp_ptr;

  always #10 clk = ~clk;

  assign sda_line = sda_c & drv_n;

  i2c_reg_target u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .scl_i          (scl_b),
    .sda_i          (sda_line),
    .sda_drive_no_o (drv_n),
    .regs_sel_i     (sel),
    .regs_val_o     (val)
  );

  // {address byte, pointer byte, data byte}
  localparam logic [23:0] VEC [6] = '{
    {8'h68, 8'h00, 8'hA5},
    {8'h68, 8'h07, 8'h3C},
    {8'h6A, 8'h02, 8'hFF},
    {8'h68, 8'h0B, 8'h11},
    {8'hD0, 8'h04, 8'h77},
    {8'h68, 8'h01, 8'hC3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s0, output logic s1);
    sda_c = b;
    hold(Q);
    scl_b = 1'b1;
    hold(1);
    s0 = sda_line;
    hold(Q - 2);
    s1 = sda_line;
    hold(1);
    scl_b = 1'b0;
    hold(Q);
  endtask

  task automatic bus_start();
    sda_c = 1'b1; scl_b = 1'b1; hold(Q);
    sda_c = 1'b0; hold(Q);
    scl_b = 1'b0; hold(Q);
  endtask

  task automatic bus_rstart();
    sda_c = 1'b1; hold(Q);
    scl_b = 1'b1; hold(Q);
    sda_c = 1'b0; hold(Q);
    scl_b = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    scl_b = 1'b0; sda_c = 1'b0; hold(Q);
    scl_b = 1'b1; hold(Q);
    sda_c = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack, output logic whole);
    logic s0, s1;
    for (int i = 7; i >= 0; i--) bit_io(d[i], s0, s1);
    bit_io(1'b1, s0, s1);
    ack   = ~s1;
    whole = (s0 == s1);
  endtask

  task automatic recv_byte(input logic ack_b, output logic [7:0] d, output logic stable);
    logic s0, s1;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s0, s1);
      d[i] = s1;
      if (s0 !== s1) stable = 1'b0;
    end
    bit_io(ack_b, s0, s1);
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < 8; r++) begin
      sel = 3'(r);
      #1;
      chk(req, val, exp_regs[r]);
    end
  endtask

  task automatic model_wr(input logic [7:0] d);
    exp_regs[exp_ptr] = d;
    exp_ptr = exp_ptr + 3'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic       ack, whole, stable, s0, s1;
    logic [7:0] a, p, d, rb;
    logic       exp_ack;

    for (int r = 0; r < 8; r++) exp_regs[r] = 8'h00;
    exp_ptr = 3'd0;

    hold(3);
    // R1 reset state
    chk("R1 sda released in reset", drv_n, 1'b1);
    rst_n = 1'b1;
    hold(4);
    chk("R1 sda released after reset", sda_line, 1'b1);
    check_regs("R1 register reset value");

    // table walk: single-byte writes, matching and non-matching addresses
    for (int v = 0; v < 6; v++) begin
      {a, p, d} = VEC[v];
      exp_ack = (a == 8'h68);
      bus_start();
      send_byte(a, ack, whole);
      chk(exp_ack ? "R2 address ack" : "R3 address rejected", ack, exp_ack);
      if (exp_ack) chk("R2 ack over whole pulse", whole, 1'b1);
      send_byte(p, ack, whole);
      chk(exp_ack ? "R4 pointer ack" : "R3 ignored pointer", ack, exp_ack);
      send_byte(d, ack, whole);
      chk(exp_ack ? "R4 data ack" : "R3 ignored data", ack, exp_ack);
      bus_stop();
      if (exp_ack) begin
        exp_ptr = p[2:0];
        model_wr(d);
      end
      check_regs(exp_ack ? "R4 register write" : "R3 registers unchanged");
    end

    // R5 burst write with wrap 6 -> 7 -> 0
    bus_start();
    send_byte(8'h68, ack, whole);
    chk("R5 address ack", ack, 1'b1);
    send_byte(8'h06, ack, whole);
    chk("R5 pointer ack", ack, 1'b1);
    exp_ptr = 3'd6;
    foreach (VEC[k]) begin
      if (k < 3) begin
        d = 8'h10 * 8'(k + 1);
        send_byte(d, ack, whole);
        chk("R5 burst data ack", ack, 1'b1);
        model_wr(d);
      end
    end
    bus_stop();
    check_regs("R5 burst write wrap");

    // R8 pointer write, repeated START, read burst R6, NACK R7
    bus_start();
    send_byte(8'h68, ack, whole);
    send_byte(8'h06, ack, whole);
    chk("R6 pointer ack", ack, 1'b1);
    exp_ptr = 3'd6;
    bus_rstart();
    send_byte(8'h69, ack, whole);
    chk("R8 read address ack after repeated start", ack, 1'b1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k == 2, rb, stable);
      chk("R6 read data", rb, exp_regs[exp_ptr]);
      chk("R10 data stable while SCL high", stable, 1'b1);
      exp_ptr = exp_ptr + 3'd1;
    end
    // R7 after NACK the target stays off the bus
    stable = 1'b1;
    for (int i = 0; i < 9; i++) begin
      bit_io(1'b1, s0, s1);
      if (!s0 || !s1) stable = 1'b0;
    end
    chk("R7 released after NACK", stable, 1'b1);
    bus_stop();

    // R6 pointer carries into a fresh read
    bus_start();
    send_byte(8'h69, ack, whole);
    chk("R6 read address ack", ack, 1'b1);
    recv_byte(1'b1, rb, stable);
    chk("R6 read continues from pointer", rb, exp_regs[exp_ptr]);
    exp_ptr = exp_ptr + 3'd1;
    bus_stop();

    // R3/R8 rejected address, then repeated START recovers
    bus_start();
    send_byte(8'h6A, ack, whole);
    chk("R3 wrong address no ack", ack, 1'b0);
    bus_rstart();
    send_byte(8'h68, ack, whole);
    chk("R8 repeated start after reject", ack, 1'b1);
    send_byte(8'h02, ack, whole);
    send_byte(8'h5E, ack, whole);
    chk("R8 data ack", ack, 1'b1);
    bus_stop();
    exp_ptr = 3'd2;
    model_wr(8'h5E);
    check_regs("R8 write after repeated start");

    // R9 clock pulses on a free bus
    scl_b = 1'b0;
    hold(Q);
    send_byte(8'h68, ack, whole);
    chk("R9 no ack without START", ack, 1'b0);
    send_byte(8'h03, ack, whole);
    chk("R9 no ack without START", ack, 1'b0);
    send_byte(8'h99, ack, whole);
    chk("R9 no ack without START", ack, 1'b0);
    sda_c = 1'b1; hold(Q);
    scl_b = 1'b1; hold(Q);
    check_regs("R9 registers unchanged on free bus");

    // R1 reset mid-run clears the bank
    rst_n = 1'b0;
    hold(2);
    rst_n = 1'b1;
    hold(4);
    for (int r = 0; r < 8; r++) exp_regs[r] = 8'h00;
    chk("R1 sda released after second reset", sda_line, 1'b1);
    check_regs("R1 registers cleared by reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule